// File: doc/BRIEF.md
# NAND Flash Strobe Sequencer

This block times a single 8-bit NAND flash transfer on the memory side of a controller. A caller raises `start` for one cycle with a direction flag, a choice between the common and the attribute memory space, and the byte to write. The block then walks through three phases: address setup, command (read or write strobe low) and address hold. It drives the matching active-low strobe, holds an address-valid qualifier across the whole access and delays driving the data bus on writes.

Each memory space has its own 32-bit timing word. The word picked by `space_attr` is latched when the access is accepted, so later changes to the words do not disturb an access already running. The active-low ready input from the flash passes through two flops, then stretches the command phase for as long as it reads low. Read data is latched as the read strobe rises. `done` pulses for one cycle once the access is over.

Top module: `nand_strobe_seq`

## Requirements
- R1: After an accepted start, `addr_valid` is high and both strobes are high for SETUP+1 cycles, where SETUP is bits 7:0 of the selected timing word.
- R2: The command strobe (`noe_n` on reads, `nwe_n` on writes) is then low for WAIT+1 cycles when ready stays high, where WAIT is bits 15:8. The other strobe stays high, and the two are never low together.
- R3: While the synchronized ready input reads low, the strobe stays low. With ready held low and released once the strobe has been low for L ≥ WAIT+1 cycles, the strobe is low for L+2 cycles in total (two synchronizer flops).
- R4: After the strobe rises, `addr_valid` stays high for HOLD cycles on writes and HOLD+1 on reads, where HOLD is bits 23:16. Then `done` is high for exactly one cycle, and `busy` and `addr_valid` are low in that cycle.
- R5: On writes, `data_oe` is low for the first HIZ cycles of the access, where HIZ is bits 31:24, and high after that until the access ends. While it is high, `wr_bus` equals the write byte. On reads, `data_oe` never rises.
- R6: `space_attr`=1 selects `attr_tmg` and `space_attr`=0 selects `common_tmg`. The selection is latched at the accepted start.
- R7: After reset, `addr_valid`, `data_oe`, `done` and `busy` are 0, both strobes are 1 and `rdata` is 0.
- R8: `busy` is high for the whole access. A `start` raised while busy has no effect: phase lengths are unchanged and no second access follows.
- R9: `rdata` takes `rd_bus` at the edge where `noe_n` rises, and keeps that value through later write accesses.
- R10: A `start` raised in the cycle where `done` is high is accepted, and the new access begins at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Access request, sampled when idle |
| is_write | input | 1 | 1 = write, 0 = read |
| space_attr | input | 1 | 1 = attribute space timing, 0 = common space timing |
| wdata | input | DW | Byte to write |
| common_tmg | input | 4*TW | Common space timing word {hiz, hold, wait, setup} |
| attr_tmg | input | 4*TW | Attribute space timing word, same layout |
| ready_n | input | 1 | Active-low wait input from the flash (asynchronous) |
| rd_bus | input | DW | Data bus as read from the flash |
| addr_valid | output | 1 | Address phase qualifier, high for the whole access |
| noe_n | output | 1 | Active-low read strobe |
| nwe_n | output | 1 | Active-low write strobe |
| data_oe | output | 1 | Data bus drive enable |
| wr_bus | output | DW | Data driven onto the bus on writes |
| rdata | output | DW | Captured read byte |
| done | output | 1 | One-cycle end-of-access pulse |
| busy | output | 1 | Access in progress |

## Verification
The end of one access and the acceptance of the next can fall in the same cycle: `done` is high while the block is already idle, so a new `start` in that cycle must be taken. The bench raises `start` in the very cycle it sees `done`, then expects `addr_valid` one cycle later. It also checks that the second access has its full setup length. A second pairing is the ready input rising while the programmed command count is still running. The bench releases ready at chosen strobe lengths and judges the strobe length against WAIT+1 and the two-flop delay.

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq #(
  parameter int TW = 8,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            is_write,
  input  logic            space_attr,
  input  logic [DW-1:0]   wdata,
  input  logic [4*TW-1:0] common_tmg,
  input  logic [4*TW-1:0] attr_tmg,
  input  logic            ready_n,
  input  logic [DW-1:0]   rd_bus,
  output logic            addr_valid,
  output logic            noe_n,
  output logic            nwe_n,
  output logic            data_oe,
  output logic [DW-1:0]   wr_bus,
  output logic [DW-1:0]   rdata,
  output logic            done,
  output logic            busy
);
  localparam int CW = TW + 1;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_CMD, S_HOLD} st_t;
  st_t st;

  logic [4*TW-1:0] cfg;
  logic [CW-1:0]   cnt;
  logic [TW-1:0]   hiz_cnt;
  logic            wr_q;
  logic [DW-1:0]   wd_q;
  logic            rdy_s1, rdy_s2;

  wire [4*TW-1:0] sel_w  = space_attr ? attr_tmg : common_tmg;
  wire [TW-1:0]   f_wait = cfg[2*TW-1:TW];
  wire [TW-1:0]   f_hold = cfg[3*TW-1:2*TW];
  wire            accept = start && (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rdy_s1 <= 1'b1;
      rdy_s2 <= 1'b1;
    end else begin
      rdy_s1 <= ready_n;
      rdy_s2 <= rdy_s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      cfg     <= '0;
      cnt     <= '0;
      hiz_cnt <= '0;
      wr_q    <= 1'b0;
      wd_q    <= '0;
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (hiz_cnt != '0) hiz_cnt <= hiz_cnt - 1'b1;
      case (st)
        S_IDLE:
          if (accept) begin
            st      <= S_SETUP;
            cfg     <= sel_w;
            cnt     <= {1'b0, sel_w[TW-1:0]};
            hiz_cnt <= sel_w[4*TW-1:3*TW];
            wr_q    <= is_write;
            wd_q    <= wdata;
          end
        S_SETUP:
          if (cnt == '0) begin
            st  <= S_CMD;
            cnt <= {1'b0, f_wait};
          end else
            cnt <= cnt - 1'b1;
        S_CMD:
          if (cnt != '0)
            cnt <= cnt - 1'b1;
          else if (rdy_s2) begin
            if (!wr_q) rdata <= rd_bus;
            if (wr_q && f_hold == '0) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else begin
              st  <= S_HOLD;
              cnt <= wr_q ? {1'b0, f_hold} : {1'b0, f_hold} + CW'(1);
            end
          end
        default:
          if (cnt == CW'(1)) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else
            cnt <= cnt - 1'b1;
      endcase
    end

  assign addr_valid = (st != S_IDLE);
  assign busy       = addr_valid;
  assign noe_n      = !(st == S_CMD && !wr_q);
  assign nwe_n      = !(st == S_CMD && wr_q);
  assign data_oe    = addr_valid && wr_q && (hiz_cnt == '0);
  assign wr_bus     = wd_q;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!noe_n && !nwe_n)); // R2
  AST_STROBE_ADDR: assert property (@(posedge clk) disable iff (!rst_n) (!noe_n || !nwe_n) |-> addr_valid); // R1
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ((!noe_n || !nwe_n) && !rdy_s2) |=> (!noe_n || !nwe_n)); // R3
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) !noe_n |-> !data_oe); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R4
  AST_BUSY_STAYS: assert property (@(posedge clk) disable iff (!rst_n) (busy && !done && start && (!noe_n || !nwe_n)) |=> busy); // R8
endmodule

// File: tb/tb_nand_strobe_seq.sv
module tb_nand_strobe_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, is_write = 1'b0, space_attr = 1'b0, ready_n = 1'b1;
  logic [7:0] wdata = '0, rd_bus = '0;
  logic [31:0] common_tmg = '0, attr_tmg = '0;
  logic addr_valid, noe_n, nwe_n, data_oe, done, busy;
  logic [7:0] wr_bus, rdata;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  nand_strobe_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write), .space_attr(space_attr),
    .wdata(wdata), .common_tmg(common_tmg), .attr_tmg(attr_tmg), .ready_n(ready_n),
    .rd_bus(rd_bus), .addr_valid(addr_valid), .noe_n(noe_n), .nwe_n(nwe_n),
    .data_oe(data_oe), .wr_bus(wr_bus), .rdata(rdata), .done(done), .busy(busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One access; nwl>0 holds ready low until the strobe has been low nwl cycles.
  task automatic run_access(input bit wr, input bit attr, input logic [7:0] wd,
                            input logic [7:0] rd, input int nwl, input bit poke);
    logic [31:0] w;
    int s, c, h, z, tot, exp_c, exp_h, exp_z, idx, bad_strobe, bad_data;
    bit seen_cmd, seen_oe, fin;
    w = attr ? attr_tmg : common_tmg;
    s = 0; c = 0; h = 0; z = 0; idx = 0; bad_strobe = 0; bad_data = 0;
    seen_cmd = 0; seen_oe = 0; fin = 0;
    @(negedge clk);
    is_write = wr; space_attr = attr; wdata = wd; rd_bus = rd;
    ready_n = (nwl > 0) ? 1'b0 : 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!fin && idx < 3000) begin
      if (done) begin
        fin = 1;
        chk(!busy && !addr_valid, "R4 idle at done", busy, 0);
      end else begin
        if (!noe_n || !nwe_n) begin
          seen_cmd = 1; c++;
          if (wr ? !noe_n : !nwe_n) bad_strobe++;
          if (nwl > 0 && c == nwl) ready_n = 1'b1;
        end else if (addr_valid && !seen_cmd) s++;
        else if (addr_valid) h++;
        if (addr_valid && !data_oe && !seen_oe) z++;
        if (data_oe) begin
          seen_oe = 1;
          if (wr_bus !== wd) bad_data++;
        end
        if (poke && idx == 2) start = 1'b1;
        else start = 1'b0;
        if (poke && idx == 2) begin is_write = !wr; space_attr = !attr; end
        idx++;
        @(negedge clk);
      end
    end
    start = 1'b0; ready_n = 1'b1;
    chk(fin, "R4 done seen (watchdog)", fin, 1);
    exp_c = (nwl > 0) ? nwl + 2 : w[15:8] + 1;
    exp_h = wr ? w[23:16] : w[23:16] + 1;
    tot   = (w[7:0] + 1) + exp_c + exp_h;
    exp_z = wr ? ((w[31:24] < tot) ? w[31:24] : tot) : tot;
    chk(s == w[7:0] + 1, "R1 setup length", s, w[7:0] + 1);
    chk(c == exp_c, (nwl > 0) ? "R3 stretched strobe" : "R2 strobe length", c, exp_c);
    chk(bad_strobe == 0, "R2 wrong strobe", bad_strobe, 0);
    chk(h == exp_h, "R4 hold length", h, exp_h);
    chk(z == exp_z, wr ? "R5 hiz length" : "R5 read no drive", z, exp_z);
    chk(bad_data == 0, "R5 wr_bus value", bad_data, 0);
    if (!wr) chk(rdata == rd, "R9 rdata capture", rdata, rd);
    @(negedge clk);
    chk(!done, "R4 done one cycle", done, 0);
    if (poke) begin
      for (int k = 0; k < 4; k++) begin
        chk(!addr_valid, "R8 poke ignored", addr_valid, 0);
        @(negedge clk);
      end
    end
  endtask

  task automatic t_reset();
    chk(!addr_valid && !data_oe && !done && !busy, "R7 reset outputs low", {addr_valid, data_oe, done, busy}, 0);
    chk(noe_n && nwe_n, "R7 strobes high", {noe_n, nwe_n}, 3);
    chk(rdata == 0, "R7 rdata zero", rdata, 0);
  endtask

  task automatic t_back_to_back();
    int s;
    common_tmg = 32'h00_01_01_02;
    @(negedge clk);
    is_write = 1'b0; space_attr = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    start = 1'b1; is_write = 1'b1;  // R10 start in done cycle
    @(negedge clk);
    start = 1'b0;
    chk(addr_valid && busy, "R10 accepted in done cycle", addr_valid, 1);
    s = 0;
    while (addr_valid && noe_n && nwe_n) begin s++; @(negedge clk); end
    chk(s == 3, "R10 full setup of second access", s, 3);
    chk(!nwe_n, "R10 second access is write", nwe_n, 0);
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    common_tmg = 32'h0; attr_tmg = 32'h0;
    run_access(0, 0, 8'h00, 8'h3C, 0, 0);        // R1 R2 R4 minimum read
    run_access(1, 0, 8'h5A, 8'h00, 0, 0);        // minimum write, hold 0
    common_tmg = 32'h04_02_05_03;
    attr_tmg   = 32'h01_03_02_04;
    run_access(1, 0, 8'hC3, 8'h00, 0, 0);        // R5 hiz 4
    run_access(0, 1, 8'h00, 8'hA5, 0, 0);        // R6 attribute read
    run_access(1, 1, 8'h11, 8'h00, 0, 0);        // R6 attribute write
    chk(rdata == 8'hA5, "R9 rdata kept over write", rdata, 8'hA5);
    common_tmg = 32'h00_01_02_01;
    run_access(1, 0, 8'h77, 8'h00, 6, 0);        // R3 write stretched
    run_access(0, 1, 8'h00, 8'h96, 5, 0);        // R3 read stretched
    run_access(0, 0, 8'h00, 8'h69, 0, 1);        // R8 poke while busy
    common_tmg = 32'h40_00_00_00;
    run_access(1, 0, 8'hEE, 8'h00, 0, 0);        // R5 hiz longer than access
    t_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule